// File: doc/BRIEF.md
# Ten-Stage Maximal-Length Pseudo-Random Bit Source

This block emits one pseudo-random bit on every clock. The bits form a maximal-length sequence. Internally it is a ten-stage shift register made of two delay lines in series: a short head line of three stages followed by a longer tail line of seven stages. The next bit that enters the head line is the XOR of the head line's last stage and the tail line's last stage, which gives the recurrence polynomial x^10 + x^3 + 1. The serial output is the last stage of the tail line.

A synchronous, active-high reset loads a fixed non-zero seed into all ten stages. A clear to zero would not work, because an all-zero register keeps its XOR feedback at zero and the sequence would stop. From the seed, the output walks through all 1023 non-zero register states and then repeats. The block has no enable and advances on every rising clock edge. It is meant for test patterns, scrambling and dither where a cheap repeatable bit stream is wanted.

Stage numbering used below: stage 1 is the head of the short line, stage 3 is its end, stage 4 is the head of the long line and stage 10 is its end. Seed bit k (LSB = k 0) goes to stage k+1.

Top module: `prbs_split_lfsr`

## Requirements
- R1: While `rst` is sampled high at a rising edge, every stage loads the seed (default 10'h200, so stage 10 = 1 and all others 0). In the cycle after that edge `bit_out` equals seed bit 9, which is 1 with the default seed, and it stays at that value for as long as reset is held.
- R2: Reset is synchronous. Raising `rst` between edges leaves `bit_out` unchanged until the next rising edge.
- R3: On each rising edge with `rst` low, stage 1 takes stage 3 XOR stage 10, and every other stage takes the previous stage's value. At the port this means bit_out[n+10] = bit_out[n+7] XOR bit_out[n].
- R4: After reset is released, the output sequence repeats with a period of exactly 1023 clocks, and no shorter window of the first ten bits reappears before then.
- R5: Every 1023-bit period of the output contains exactly 512 ones and 511 zeros.
- R6: After reset, the register never holds all zeros. At the port, the output never shows ten consecutive zeros.
- R7: The output reflects the state on the first clock after reset is released, with no warm-up cycles. The first bit is stage 10 of the seed, and each following clock produces the next bit of the recurrence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock; the register advances on every edge |
| rst | input | 1 | Synchronous active-high reset; loads the seed |
| bit_out | output | 1 | Serial pseudo-random bit, stage 10 of the register |

## Verification
The assertions assume that `rst` is high at the first rising clock edge, so the register never runs from its unknown power-up contents. They also assume that `rst` changes only between edges. The bench raises reset at time zero and holds it for several edges. After that it changes `rst` only at falling edges, with random run lengths drawn from a fixed-seed generator between directed resets. One run of 2046 bits is left free of resets so the period and the balance of ones and zeros can be measured over two full periods.

// File: rtl/prbs_pkg.sv
package prbs_pkg;
    localparam int unsigned PRBS_HEAD_LEN  = 3;
    localparam int unsigned PRBS_TAIL_LEN  = 7;
    localparam int unsigned PRBS_TOTAL_LEN = PRBS_HEAD_LEN + PRBS_TAIL_LEN;
    localparam logic [PRBS_TOTAL_LEN-1:0] PRBS_SEED = 10'h200;
endpackage

// File: rtl/prbs_delay_line.sv
module prbs_delay_line #(
    parameter int unsigned     DEPTH = 3,
    parameter logic [DEPTH-1:0] INIT = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             din,
    output logic             dout,
    output logic [DEPTH-1:0] stages
);
    logic [DEPTH-1:0] stg_q;

    generate
        if (DEPTH == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) stg_q <= INIT;
                else     stg_q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) stg_q <= INIT;
                else     stg_q <= {stg_q[DEPTH-2:0], din};
            end
        end
    endgenerate

    assign dout   = stg_q[DEPTH-1];
    assign stages = stg_q;
endmodule

// File: rtl/prbs_feedback.sv
module prbs_feedback (
    input  logic tap_short,
    input  logic tap_long,
    output logic fb
);
    always_comb begin
        fb = tap_short ^ tap_long;
    end
endmodule

// File: rtl/prbs_split_lfsr.sv
module prbs_split_lfsr
    import prbs_pkg::*;
#(
    parameter int unsigned HEAD_LEN = PRBS_HEAD_LEN,
    parameter int unsigned TAIL_LEN = PRBS_TAIL_LEN,
    parameter logic [HEAD_LEN+TAIL_LEN-1:0] SEED = PRBS_SEED
) (
    input  logic clk,
    input  logic rst,
    output logic bit_out
);
    localparam int unsigned TOTAL_LEN = HEAD_LEN + TAIL_LEN;

    logic                head_out;
    logic                tail_out;
    logic                fb_bit;
    logic [HEAD_LEN-1:0] head_stages;
    logic [TAIL_LEN-1:0] tail_stages;
    logic [TOTAL_LEN-1:0] reg_state;

    prbs_feedback u_fb (
        .tap_short (head_out),
        .tap_long  (tail_out),
        .fb        (fb_bit)
    );

    prbs_delay_line #(
        .DEPTH (HEAD_LEN),
        .INIT  (SEED[HEAD_LEN-1:0])
    ) u_head (
        .clk    (clk),
        .rst    (rst),
        .din    (fb_bit),
        .dout   (head_out),
        .stages (head_stages)
    );

    prbs_delay_line #(
        .DEPTH (TAIL_LEN),
        .INIT  (SEED[TOTAL_LEN-1:HEAD_LEN])
    ) u_tail (
        .clk    (clk),
        .rst    (rst),
        .din    (head_out),
        .dout   (tail_out),
        .stages (tail_stages)
    );

    assign reg_state = {tail_stages, head_stages};
    assign bit_out   = tail_out;

    // R1: a reset edge leaves the full seed in both lines
    assert_seed_load_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> reg_state == SEED);

    // R3: the head stage takes the XOR of the two line ends
    assert_feedback_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> head_stages[0] == $past(head_out ^ tail_out));

    // R3: the tail line is fed by the end of the head line
    assert_link_R3: assert property (@(posedge clk) disable iff (rst)
        !rst |=> tail_stages[0] == $past(head_out));

    // R6: lock-up state is never reached
    assert_no_zero_R6: assert property (@(posedge clk) disable iff (rst)
        reg_state != '0);
endmodule

// File: tb/sim_prbs_split_lfsr.sv
`timescale 1ns/1ps
module sim_prbs_split_lfsr;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_out;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    logic [9:0]  model;
    localparam logic [9:0] SEED_V = 10'h200;

    always #2.5 clk = ~clk;

    prbs_split_lfsr u0 (.clk(clk), .rst(rst), .bit_out(bit_out));

    function automatic logic [9:0] next_state(input logic [9:0] s);
        return {s[8:0], s[2] ^ s[9]};
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: bit_out=%b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int cycles);
        rst = 1'b1;
        repeat (cycles) begin
            @(posedge clk); @(negedge clk);
            check("R1 held", bit_out, SEED_V[9]);
        end
        rst = 1'b0;
        model = SEED_V;
        check("R7 first bit", bit_out, model[9]);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); @(negedge clk);
            model = next_state(model);
            check("R3 sequence", bit_out, model[9]);
        end
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        logic bits [0:2045];
        int   ones, mism, early, zrun, maxz;
        int unsigned r;
        r = $urandom(32'd4711);
        @(negedge clk);
        do_reset(3);

        // collect two full periods with no reset
        bits[0] = bit_out;
        for (int i = 1; i < 2046; i++) begin
            @(posedge clk); @(negedge clk);
            model = next_state(model);
            check("R3 sequence", bit_out, model[9]);
            bits[i] = bit_out;
        end
        mism = 0;
        for (int i = 0; i < 1023; i++) if (bits[i] !== bits[i+1023]) mism++;
        check_int("R4 period 1023 mismatches", mism, 0);
        early = 0;
        for (int k = 1; k < 1023; k++) begin
            logic same = 1'b1;
            for (int j = 0; j < 10; j++) if (bits[k+j] !== bits[j]) same = 1'b0;
            if (same) early++;
        end
        check_int("R4 no shorter period", early, 0);
        ones = 0;
        for (int i = 0; i < 1023; i++) if (bits[i]) ones++;
        check_int("R5 ones per period", ones, 512);
        ones = 0;
        for (int i = 500; i < 1523; i++) if (bits[i]) ones++;
        check_int("R5 ones in shifted window", ones, 512);
        zrun = 0; maxz = 0;
        for (int i = 0; i < 2046; i++) begin
            zrun = bits[i] ? 0 : zrun + 1;
            if (zrun > maxz) maxz = zrun;
        end
        check_int("R6 longest zero run", maxz, 9);
        check_int("R3 port recurrence", int'(bits[17] ^ bits[14] ^ bits[7]), 0);

        // R2: reset raised between edges has no effect until the edge
        run(13);
        rst = 1'b1;
        #1;
        check("R2 sync reset", bit_out, model[9]);
        @(posedge clk); @(negedge clk);
        check("R1 seed after edge", bit_out, SEED_V[9]);
        do_reset(1);
        run(30);

        // random run lengths and reset durations
        for (int t = 0; t < 8; t++) begin
            r = $urandom_range(2, 400);
            run(int'(r));
            rst = 1'b1;
            #1;
            check("R2 sync reset", bit_out, model[9]);
            do_reset(int'($urandom_range(1, 4)));
        end
        run(50);
        finish_run();
    end
endmodule